// File: doc/BRIEF.md
# Transmit/Receive Word Buffer with Event Flags

This block sits between a serial shift engine and a register interface. It holds two word queues, one feeding the engine with words to send and one collecting words the engine has received. Software side accesses go through single-cycle write and read strobes with a 3-bit select. These strobes reach the two data windows, the two fill-level registers, the receive trigger configuration, the status register and the enable register. The engine side uses a one-cycle transmit word request, which pops the head of the transmit queue, and a one-cycle receive push.

Six conditions latch into a sticky status register: underrun, overflow, transmit drained, transfer finished, transmit low-water and receive threshold. Each status bit has an enable bit at the same position. The single interrupt line is high while any enabled status bit is set. A small state machine tracks whether the transmit queue holds engine-bound data. Its states are `DRN_EMPTY` and `DRN_LOADED`. The transition `DRN_EMPTY -> DRN_LOADED` happens on an accepted transmit write. The transition `DRN_LOADED -> DRN_EMPTY` happens in two cases. The first is an engine pop that takes the last word, which raises the drained event. The second is a flush or soft reset, which raises no event.

Top module: `xfer_fifo_hub`

## Requirements
- R1: Each queue holds 32 words, and its level can be read back: select 2 for transmit and select 3 for receive. A word written to the transmit window (select 0) while the transmit queue is full is discarded. Words leave in the order they were written.
- R2: Writing the value 0 to a level register empties that queue at the next clock edge. Writing any nonzero value to a level register has no effect.
- R3: Reading the receive window (select 1) returns the oldest word and removes it. If the receive queue is empty, the read returns 0 and the level stays 0.
- R4: The trigger register (select 4) holds a code in bits [2:0] and a trigger enable in bit 3. The code selects a threshold of 2^code words for codes 0 to 5, and 32 words for codes 6 and 7.
- R5: While the trigger enable is set and the receive level is at or above the threshold, status bit 0 is set. With the enable clear, bit 0 is not set.
- R6: Status bit 9 is set when an engine request takes the last word out of the transmit queue. Emptying the queue by flush sets no status bit.
- R7: A receive push while the receive queue is full sets status bit 12 and discards that word.
- R8: An engine request while the transmit queue is empty sets status bit 13 and presents 0 on the engine data output.
- R9: A pulse on eng_xfer_done sets status bit 8. An engine pop that leaves exactly 16 words in the transmit queue sets status bit 4.
- R10: Status bits (select 5) stay set until software writes 1 to them. Writing 0 to a bit leaves it unchanged. A new event in the same cycle as a clear wins.
- R11: The enable register (select 6) uses the same bit positions as status and reads back as written. The irq output is high exactly when some status bit and its enable are both 1.
- R12: A soft_rst pulse empties both queues and clears all status bits. The enable register and the trigger register keep their values.
- R13: After rst_n, both levels, status, enables and the trigger register read 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse (queues and status only) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_sel) |
| eng_tx_req | input | 1 | Engine requests one transmit word |
| eng_tx_data | output | 16 | Head of the transmit queue, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers one received word |
| eng_rx_data | input | 16 | Received word |
| eng_xfer_done | input | 1 | Engine signals end of a transfer |
| irq | output | 1 | Combined interrupt |

## Verification
The in-line assertions check several behaviours on every cycle. Levels never exceed 32, and a flush empties a queue by the next edge. A write to a full transmit queue leaves its level at 32. A status bit only drops through a write-1 clear or a soft reset. Overflow, underrun and transfer-finished events land in status one edge later, and the receive threshold comparison always sets bit 0. Other behaviours show only in the bench's scenarios. These are word ordering through the queues, the discarded 33rd word, and the threshold boundary for each of the eight trigger codes. They also include the low-water and drained flags after a full drain, the absence of a drained flag after a flush, and the survival of enables and trigger settings across a soft reset.

// File: rtl/xfh_pkg.sv
package xfh_pkg;

    localparam int STAT_W = 14;
    localparam int TRIG_W = 4;

    localparam int BIT_RXTRG = 0;
    localparam int BIT_TXLOW = 4;
    localparam int BIT_XEND  = 8;
    localparam int BIT_DRAIN = 9;
    localparam int BIT_OVF   = 12;
    localparam int BIT_UDR   = 13;

    localparam logic [STAT_W-1:0] STAT_MASK =
        (STAT_W'(1) << BIT_RXTRG) | (STAT_W'(1) << BIT_TXLOW) |
        (STAT_W'(1) << BIT_XEND)  | (STAT_W'(1) << BIT_DRAIN) |
        (STAT_W'(1) << BIT_OVF)   | (STAT_W'(1) << BIT_UDR);

    typedef enum logic [2:0] {
        SEL_TXWIN = 3'd0,
        SEL_RXWIN = 3'd1,
        SEL_TXLVL = 3'd2,
        SEL_RXLVL = 3'd3,
        SEL_TRIG  = 3'd4,
        SEL_STAT  = 3'd5,
        SEL_IEN   = 3'd6
    } reg_sel_e;

    typedef enum logic {
        DRN_EMPTY  = 1'b0,
        DRN_LOADED = 1'b1
    } drain_state_e;

endpackage

// File: rtl/xfh_fifo.sv
module xfh_fifo #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              push_ok,
    output logic              pop_ok
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [LVL_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (count == LVL_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = store[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R2
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R1
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == LVL_W'(DEPTH)));

endmodule

// File: rtl/xfh_drain_fsm.sv
module xfh_drain_fsm
    import xfh_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [LVL_W-1:0] level,
    output logic             drained
);

    drain_state_e state_q;
    drain_state_e state_d;
    logic         last_out;

    assign last_out = pop_ok && !push_ok && (level == LVL_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRN_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRN_EMPTY: begin
                if (!flush && push_ok) begin
                    state_d = DRN_LOADED;
                end
            end
            DRN_LOADED: begin
                if (flush || last_out) begin
                    state_d = DRN_EMPTY;
                end
            end
            default: state_d = DRN_EMPTY;
        endcase
    end

    always_comb begin
        drained = 1'b0;
        unique case (state_q)
            DRN_EMPTY:  drained = 1'b0;
            DRN_LOADED: drained = !flush && last_out;
            default:    drained = 1'b0;
        endcase
    end

    // R6
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> (level == '0));

endmodule

// File: rtl/xfh_status.sv
module xfh_status
    import xfh_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wmask,
    input  logic              ien_wr,
    input  logic [STAT_W-1:0] ien_wdata,
    input  logic              trig_wr,
    input  logic [TRIG_W-1:0] trig_wdata,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] ien_q,
    output logic [TRIG_W-1:0] trig_q,
    output logic              irq
);

    localparam int MAX_CODE = $clog2(DEPTH);

    logic [2:0]        code_sat;
    logic [LVL_W-1:0]  thr;
    logic              rx_hit;
    logic [STAT_W-1:0] set_all;
    logic [STAT_W-1:0] clr;

    assign code_sat = (trig_q[2:0] > 3'(MAX_CODE)) ? 3'(MAX_CODE) : trig_q[2:0];
    assign thr      = LVL_W'(1) << code_sat;
    assign rx_hit   = trig_q[3] && (rx_level >= thr);
    assign clr      = stat_wr ? stat_wmask : '0;

    always_comb begin
        set_all            = evt_set;
        set_all[BIT_RXTRG] = evt_set[BIT_RXTRG] | rx_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (soft_clr) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr) | set_all) & STAT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            trig_q <= '0;
        end else begin
            if (ien_wr) begin
                ien_q <= ien_wdata & STAT_MASK;
            end
            if (trig_wr) begin
                trig_q <= trig_wdata;
            end
        end
    end

    assign irq = |(stat_q & ien_q);

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_clr |=> ((stat_q & $past(stat_q & ~clr)) == $past(stat_q & ~clr)));

    // R12
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (stat_q == '0));

    // R5
    rx_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && trig_q[3] && (rx_level >= thr)) |=> stat_q[BIT_RXTRG]);

endmodule

// File: rtl/xfer_fifo_hub.sv
module xfer_fifo_hub
    import xfh_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int WORD_W      = 16,
    parameter int REG_W       = 16,
    parameter int TX_LOW_MARK = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_tx_req,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    input  logic              eng_xfer_done,
    output logic              irq
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    reg_sel_e          sel;
    logic              wr_txwin, rd_rxwin;
    logic              wr_txlvl, wr_rxlvl;
    logic              wr_trig, wr_stat, wr_ien;
    logic              zero_wr;
    logic              tx_flush, rx_flush;

    logic [WORD_W-1:0] tx_head, rx_head;
    logic [LVL_W-1:0]  tx_level, rx_level, tx_after;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic              drained;
    logic              tx_low_evt;

    logic [STAT_W-1:0] evt;
    logic [STAT_W-1:0] stat_q, ien_q;
    logic [TRIG_W-1:0] trig_q;

    assign sel      = reg_sel_e'(reg_sel);
    assign wr_txwin = reg_wr && (sel == SEL_TXWIN);
    assign rd_rxwin = reg_rd && (sel == SEL_RXWIN);
    assign wr_txlvl = reg_wr && (sel == SEL_TXLVL);
    assign wr_rxlvl = reg_wr && (sel == SEL_RXLVL);
    assign wr_trig  = reg_wr && (sel == SEL_TRIG);
    assign wr_stat  = reg_wr && (sel == SEL_STAT);
    assign wr_ien   = reg_wr && (sel == SEL_IEN);
    assign zero_wr  = (reg_wdata == '0);
    assign tx_flush = soft_rst || (wr_txlvl && zero_wr);
    assign rx_flush = soft_rst || (wr_rxlvl && zero_wr);

    xfh_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .push    (wr_txwin),
        .wdata   (WORD_W'(reg_wdata)),
        .pop     (eng_tx_req),
        .head    (tx_head),
        .level   (tx_level),
        .full    (tx_full),
        .empty   (tx_empty),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok)
    );

    xfh_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .push    (eng_rx_push),
        .wdata   (eng_rx_data),
        .pop     (rd_rxwin),
        .head    (rx_head),
        .level   (rx_level),
        .full    (rx_full),
        .empty   (rx_empty),
        .push_ok (rx_push_ok),
        .pop_ok  (rx_pop_ok)
    );

    xfh_drain_fsm #(.LVL_W(LVL_W)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok),
        .level   (tx_level),
        .drained (drained)
    );

    assign tx_after   = tx_level + LVL_W'(tx_push_ok) - LVL_W'(tx_pop_ok);
    assign tx_low_evt = tx_pop_ok && (tx_after == LVL_W'(TX_LOW_MARK));

    always_comb begin
        evt            = '0;
        evt[BIT_UDR]   = eng_tx_req && tx_empty;
        evt[BIT_OVF]   = eng_rx_push && rx_full;
        evt[BIT_DRAIN] = drained;
        evt[BIT_XEND]  = eng_xfer_done;
        evt[BIT_TXLOW] = tx_low_evt;
    end

    xfh_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_rst),
        .evt_set    (evt),
        .stat_wr    (wr_stat),
        .stat_wmask (STAT_W'(reg_wdata)),
        .ien_wr     (wr_ien),
        .ien_wdata  (STAT_W'(reg_wdata)),
        .trig_wr    (wr_trig),
        .trig_wdata (TRIG_W'(reg_wdata)),
        .rx_level   (rx_level),
        .stat_q     (stat_q),
        .ien_q      (ien_q),
        .trig_q     (trig_q),
        .irq        (irq)
    );

    assign eng_tx_data = tx_empty ? '0 : tx_head;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_TXWIN: reg_rdata = '0;
            SEL_RXWIN: reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
            SEL_TXLVL: reg_rdata = REG_W'(tx_level);
            SEL_RXLVL: reg_rdata = REG_W'(rx_level);
            SEL_TRIG:  reg_rdata = REG_W'(trig_q);
            SEL_STAT:  reg_rdata = REG_W'(stat_q);
            SEL_IEN:   reg_rdata = REG_W'(ien_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R7
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !soft_rst) |=> stat_q[BIT_OVF]);

    // R8
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_req && (tx_level == '0) && !soft_rst) |=> stat_q[BIT_UDR]);

    // R9
    xfer_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_done && !soft_rst) |=> stat_q[BIT_XEND]);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0) && (ien_q != '0));

    // R3
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxwin && rx_empty && !eng_rx_push) |=> (rx_level == '0));

endmodule

// File: tb/xfer_fifo_hub_bench.sv
`timescale 1ns/1ps
module xfer_fifo_hub_bench;

    localparam logic [2:0] S_TXWIN = 3'd0;
    localparam logic [2:0] S_RXWIN = 3'd1;
    localparam logic [2:0] S_TXLVL = 3'd2;
    localparam logic [2:0] S_RXLVL = 3'd3;
    localparam logic [2:0] S_TRIG  = 3'd4;
    localparam logic [2:0] S_STAT  = 3'd5;
    localparam logic [2:0] S_IEN   = 3'd6;

    // {code[2:0], expected threshold[5:0]}
    localparam logic [8:0] TRIG_TAB [8] = '{
        {3'd0, 6'd1},  {3'd1, 6'd2},  {3'd2, 6'd4},  {3'd3, 6'd8},
        {3'd4, 6'd16}, {3'd5, 6'd32}, {3'd6, 6'd32}, {3'd7, 6'd32}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        eng_tx_req = 1'b0;
    logic [15:0] eng_tx_data;
    logic        eng_rx_push = 1'b0;
    logic [15:0] eng_rx_data = 16'd0;
    logic        eng_xfer_done = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    xfer_fifo_hub u_xfer_fifo_hub (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .eng_tx_req    (eng_tx_req),
        .eng_tx_data   (eng_tx_data),
        .eng_rx_push   (eng_rx_push),
        .eng_rx_data   (eng_rx_data),
        .eng_xfer_done (eng_xfer_done),
        .irq           (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output int v);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = s;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_push(input logic [15:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop(output int d);
        @(negedge clk);
        eng_tx_req = 1'b1;
        #1 d = int'(eng_tx_data);
        @(negedge clk);
        eng_tx_req = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int v;
        int first;
        int last;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        rd_reg(S_TXLVL, v); chk("R13 tx level", v, 0);
        rd_reg(S_RXLVL, v); chk("R13 rx level", v, 0);
        rd_reg(S_STAT, v);  chk("R13 status", v, 0);
        rd_reg(S_IEN, v);   chk("R13 enables", v, 0);
        rd_reg(S_TRIG, v);  chk("R13 trigger", v, 0);
        #1 chk("R13 irq", int'(irq), 0);

        // R4 / R5 threshold table
        for (int i = 0; i < 8; i++) begin
            int code;
            int thr;
            code = int'(TRIG_TAB[i][8:6]);
            thr  = int'(TRIG_TAB[i][5:0]);
            pulse_soft();
            wr_reg(S_TRIG, 16'(8 + code));
            for (int k = 0; k < thr - 1; k++) eng_push(16'(k));
            rd_reg(S_STAT, v);
            chk($sformatf("R5 below threshold code %0d", code), v & 1, 0);
            eng_push(16'h0FF);
            rd_reg(S_STAT, v);
            chk($sformatf("R4 threshold reached code %0d", code), v & 1, 1);
            rd_reg(S_RXLVL, v);
            chk($sformatf("R1 rx level code %0d", code), v, thr);
        end

        // R5 disabled trigger
        pulse_soft();
        wr_reg(S_TRIG, 16'h0000);
        eng_push(16'h0001);
        rd_reg(S_STAT, v); chk("R5 trigger disabled", v, 0);

        // R1 / R6 / R9 transmit path
        pulse_soft();
        for (int k = 0; k < 33; k++) wr_reg(S_TXWIN, 16'(16'h100 + k));
        rd_reg(S_TXLVL, v); chk("R1 tx level full", v, 32);
        eng_pop(first);
        last = first;
        for (int k = 1; k < 32; k++) eng_pop(last);
        chk("R1 first tx word", first, 16'h100);
        chk("R1 33rd word dropped", last, 16'h11F);
        rd_reg(S_STAT, v); chk("R6 R9 drained and low mark", v, 16'h0210);

        // R8 underrun
        eng_pop(v); chk("R8 underrun data", v, 0);
        rd_reg(S_STAT, v); chk("R8 underrun flag", v, 16'h2210);

        // R10 write-1-to-clear
        wr_reg(S_STAT, 16'h0200);
        rd_reg(S_STAT, v); chk("R10 clear one bit", v, 16'h2010);
        wr_reg(S_STAT, 16'h0000);
        rd_reg(S_STAT, v); chk("R10 zero write sticky", v, 16'h2010);

        // R11 interrupt
        #1 chk("R11 irq masked", int'(irq), 0);
        wr_reg(S_IEN, 16'h2000);
        #1 chk("R11 irq enabled", int'(irq), 1);
        rd_reg(S_IEN, v); chk("R11 enable readback", v, 16'h2000);
        wr_reg(S_IEN, 16'h0001);
        #1 chk("R11 irq other enable", int'(irq), 0);
        wr_reg(S_STAT, 16'h3FFF);
        rd_reg(S_STAT, v); chk("R10 clear all", v, 0);

        // R2 flush via level write, R6 no drained on flush
        wr_reg(S_TXWIN, 16'hAAAA);
        wr_reg(S_TXLVL, 16'h0005);
        rd_reg(S_TXLVL, v); chk("R2 nonzero level write ignored", v, 1);
        wr_reg(S_TXLVL, 16'h0000);
        rd_reg(S_TXLVL, v); chk("R2 tx flush", v, 0);
        rd_reg(S_STAT, v); chk("R6 flush no event", v, 0);

        // R3 receive window order and empty read
        wr_reg(S_RXLVL, 16'h0000);
        eng_push(16'h0011); eng_push(16'h0022); eng_push(16'h0033);
        rd_reg(S_RXWIN, v); chk("R3 rx word 0", v, 16'h0011);
        rd_reg(S_RXWIN, v); chk("R3 rx word 1", v, 16'h0022);
        rd_reg(S_RXLVL, v); chk("R3 rx level after reads", v, 1);
        wr_reg(S_RXLVL, 16'h0000);
        rd_reg(S_RXLVL, v); chk("R2 rx flush", v, 0);
        rd_reg(S_RXWIN, v); chk("R3 empty read data", v, 0);
        rd_reg(S_RXLVL, v); chk("R3 empty read level", v, 0);

        // R7 overflow
        for (int k = 0; k < 33; k++) eng_push(16'(16'h200 + k));
        rd_reg(S_RXLVL, v); chk("R7 rx level capped", v, 32);
        rd_reg(S_STAT, v); chk("R7 overflow flag", v, 16'h1000);
        rd_reg(S_RXWIN, v); chk("R7 oldest word kept", v, 16'h200);

        // R9 transfer end
        @(negedge clk); eng_xfer_done = 1'b1;
        @(negedge clk); eng_xfer_done = 1'b0;
        rd_reg(S_STAT, v); chk("R9 transfer end flag", v, 16'h1100);

        // R12 soft reset
        wr_reg(S_IEN, 16'h1000);
        wr_reg(S_TRIG, 16'h000B);
        #1 chk("R11 irq overflow enabled", int'(irq), 1);
        pulse_soft();
        rd_reg(S_STAT, v);  chk("R12 status cleared", v, 0);
        rd_reg(S_RXLVL, v); chk("R12 rx emptied", v, 0);
        rd_reg(S_TXLVL, v); chk("R12 tx emptied", v, 0);
        rd_reg(S_IEN, v);   chk("R12 enables kept", v, 16'h1000);
        rd_reg(S_TRIG, v);  chk("R12 trigger kept", v, 16'h000B);
        #1 chk("R12 irq low", int'(irq), 0);

        summary();
        $finish;
    end

endmodule